// File: doc/BRIEF.md
# Packed Halfword Unary Bit-Count Unit

This unit treats a source word as a set of independent 16-bit lanes and applies one single-operand operation to every lane at once. The operations are a saturating absolute value, a count of leading redundant sign bits, a leading-zero count that is gated by the sign of the lane, a leading-one count that is also gated by the sign of the lane, and an exchange of the two halfwords inside each 32-bit group. A parameter sets the datapath to 32 bits (two lanes) or 64 bits (four lanes).

The unit decodes the 32-bit instruction word on its own. When the valid strobe is high it registers the result, an illegal-instruction indication and an output strobe. These appear one clock after the request. A lane that saturates in the absolute value operation sets a sticky flag. Only reset clears this flag. Count results are written zero-extended into their 16-bit lane. The unit does not read or write a register file, and it has no control or status register interface.

Top module: `phu_top`

## Requirements
- R1: A request with valid_i high at a rising edge produces out_valid_o high after that edge, and result_o and illegal_o updated at that same edge. Without a request, out_valid_o is low. The instruction is accepted when bits [6:0] are 1111111 and bits [14:12] are 000. Bits [31:25] and [24:20] then select the operation: 1010110/10001 absolute value, 1010111/01000 redundant-sign count, 1010111/01001 zero count, 1010111/01011 one count, 1010110/11001 halfword swap.
- R2: Absolute value gives each lane its magnitude as a 16-bit value.
- R3: In absolute value, a lane holding 0x8000 gives 0x7FFF and sets sat_o. Once sat_o is set it stays set until reset.
- R4: The redundant-sign count gives the number of bits after bit 15 that equal bit 15 (0 to 15). Both 0x0000 and 0xFFFF give 15.
- R5: The zero count gives 0 for a lane with bit 15 set. Otherwise it gives the number of leading zeros, which is 16 for 0x0000.
- R6: The one count gives 0 for a lane with bit 15 clear. Otherwise it gives the number of leading ones, which is 16 for 0xFFFF.
- R7: Halfword swap exchanges bits [15:0] and [31:16] inside every 32-bit group, and each group is handled separately.
- R8: Any other opcode, funct3, funct7 or sub-opcode value raises illegal_o and forces result_o to zero. It leaves sat_o unchanged, even when the source holds 0x8000.
- R9: After reset, result_o is zero and out_valid_o, illegal_o and sat_o are low.
- R10: Instruction bits [11:7] and [19:15] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| instr_i | input | 32 | Instruction word |
| src_i | input | XLEN | Packed source operand |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | XLEN | Packed result |
| illegal_o | output | 1 | Request was not a recognised operation |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A wrong decode shows up in the very next output cycle, either as illegal_o on a legal encoding or as the lanes of the wrong operation. Because sat_o is sticky, a saturation event that was missed or raised by mistake stays visible at the port on every later request. The bench therefore tracks the expected flag across the whole run, and the first divergence points to the request that caused it. The redundant-sign, zero and one counts differ only at the all-zero and all-one lanes and at the sign boundary, so directed requests cover exactly those lanes.

// File: rtl/phu_pkg.sv
package phu_pkg;

  typedef enum logic [2:0] {
    OP_ABS  = 3'd0,
    OP_CLRS = 3'd1,
    OP_CLZ  = 3'd2,
    OP_CLO  = 3'd3,
    OP_SWAP = 3'd4,
    OP_NONE = 3'd7
  } phu_op_e;

  localparam logic [6:0] MAJOR_OPC = 7'b1111111;
  localparam logic [2:0] MINOR_F3  = 3'b000;
  localparam logic [6:0] F7_GRP_A  = 7'b1010110;
  localparam logic [6:0] F7_GRP_B  = 7'b1010111;

  // Leading zeros of a 16-bit value; 16 when the value is zero.
  function automatic logic [4:0] lead_zeros16(input logic [15:0] v);
    logic [4:0] n;
    n = 5'd16;
    for (int i = 0; i < 16; i++)
      if (v[i]) n = 5'(15 - i);
    return n;
  endfunction

  // Bits below the sign that repeat it (0..15).
  function automatic logic [4:0] sign_repeats16(input logic [15:0] v);
    logic [14:0] d;
    logic [4:0]  n;
    d = v[14:0] ^ {15{v[15]}};
    n = 5'd15;
    for (int i = 0; i < 15; i++)
      if (d[i]) n = 5'(14 - i);
    return n;
  endfunction

  // Magnitude with clamp; bit 16 of the return is the clamp event.
  function automatic logic [16:0] abs_clamp16(input logic [15:0] v);
    if (v == 16'h8000) return {1'b1, 16'h7FFF};
    if (v[15])         return {1'b0, 16'(-v)};
    return {1'b0, v};
  endfunction

endpackage

// File: rtl/phu_decode.sv
module phu_decode
  import phu_pkg::*;
(
  input  logic [31:0] instr_i,
  output phu_op_e     op_o,
  output logic        illegal_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] sub;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];
  assign sub = instr_i[24:20];

  always_comb begin
    op_o = OP_NONE;
    if (opc == MAJOR_OPC && f3 == MINOR_F3) begin
      unique case ({f7, sub})
        {F7_GRP_A, 5'b10001}: op_o = OP_ABS;
        {F7_GRP_B, 5'b01000}: op_o = OP_CLRS;
        {F7_GRP_B, 5'b01001}: op_o = OP_CLZ;
        {F7_GRP_B, 5'b01011}: op_o = OP_CLO;
        {F7_GRP_A, 5'b11001}: op_o = OP_SWAP;
        default:              op_o = OP_NONE;
      endcase
    end
  end

  assign illegal_o = (op_o == OP_NONE);
endmodule

// File: rtl/phu_lane.sv
module phu_lane
  import phu_pkg::*;
(
  input  phu_op_e     op_i,
  input  logic [15:0] own_i,
  input  logic [15:0] partner_i,
  output logic [15:0] res_o,
  output logic        clamp_o
);
  logic [16:0] mag;
  assign mag = abs_clamp16(own_i);

  always_comb begin
    res_o   = '0;
    clamp_o = 1'b0;
    case (op_i)
      OP_ABS: begin
        res_o   = mag[15:0];
        clamp_o = mag[16];
      end
      OP_CLRS: res_o = {11'd0, sign_repeats16(own_i)};
      OP_CLZ:  res_o = own_i[15] ? 16'd0 : {11'd0, lead_zeros16(own_i)};
      OP_CLO:  res_o = own_i[15] ? {11'd0, lead_zeros16(~own_i)} : 16'd0;
      OP_SWAP: res_o = partner_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/phu_top.sv
module phu_top
  import phu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o,
  output logic            sat_o
);
  localparam int LANES = XLEN / 16;

  phu_op_e          op;
  logic             dec_illegal;
  logic [XLEN-1:0]  lane_res;
  logic [LANES-1:0] lane_clamp;
  logic             sat_event;

  phu_decode u_dec (
    .instr_i  (instr_i),
    .op_o     (op),
    .illegal_o(dec_illegal)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    phu_lane u_lane (
      .op_i     (op),
      .own_i    (src_i[16*g +: 16]),
      .partner_i(src_i[16*(g ^ 1) +: 16]),
      .res_o    (lane_res[16*g +: 16]),
      .clamp_o  (lane_clamp[g])
    );
  end

  assign sat_event = valid_i && !dec_illegal && (|lane_clamp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      illegal_o   <= 1'b0;
      sat_o       <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= dec_illegal ? '0 : lane_res;
        illegal_o <= dec_illegal;
      end
      if (sat_event) sat_o <= 1'b1;
    end
  end
endmodule

// File: rtl/phu_chk.sv
module phu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic            dec_illegal,
  input logic            sat_event,
  input logic            out_valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic            sat_o
);
  // R1
  req_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> out_valid_o);
  // R1
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !out_valid_o);
  // R3
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |=> sat_o);
  // R3
  sat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_o) |-> $past(sat_event));
  // R8
  illegal_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_illegal) |=> $stable(sat_o));
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && illegal_o) |-> (result_o == '0));
endmodule

bind phu_top phu_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_i    (valid_i),
  .dec_illegal(dec_illegal),
  .sat_event  (sat_event),
  .out_valid_o(out_valid_o),
  .result_o   (result_o),
  .illegal_o  (illegal_o),
  .sat_o      (sat_o)
);

// File: tb/tb_phu_top.sv
module tb_phu_top;
  localparam int XLEN = 64;
  localparam int LN   = XLEN / 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] src_i = '0;
  logic            out_valid_o, illegal_o, sat_o;
  logic [XLEN-1:0] result_o;

  int errors = 0;
  int checks = 0;
  logic exp_sat = 1'b0;

  always #10 clk = ~clk;

  phu_top #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .src_i(src_i), .out_valid_o(out_valid_o), .result_o(result_o),
    .illegal_o(illegal_o), .sat_o(sat_o)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // op codes: 0 abs, 1 sign-repeat, 2 zeros, 3 ones, 4 swap
  function automatic logic [31:0] mk(input int op, input logic [4:0] rd, input logic [4:0] rs1);
    logic [11:0] sel;
    case (op)
      0: sel = 12'b1010110_10001;
      1: sel = 12'b1010111_01000;
      2: sel = 12'b1010111_01001;
      3: sel = 12'b1010111_01011;
      default: sel = 12'b1010110_11001;
    endcase
    return {sel, rs1, 3'b000, rd, 7'b1111111};
  endfunction

  function automatic int run_len(input logic [15:0] v, input int from, input logic b);
    int n = 0;
    int i = from;
    while (i >= 0 && v[i] == b) begin n++; i--; end
    return n;
  endfunction

  function automatic logic [XLEN-1:0] model(input int op, input logic [XLEN-1:0] s, output logic clamp);
    logic [XLEN-1:0] r;
    clamp = 1'b0;
    for (int k = 0; k < LN; k++) begin
      logic [15:0] v;
      int sv;
      v  = s[16*k +: 16];
      sv = $signed(v);
      case (op)
        0: begin
          if (sv == -32768) begin r[16*k +: 16] = 16'h7FFF; clamp = 1'b1; end
          else r[16*k +: 16] = 16'(sv < 0 ? -sv : sv);
        end
        1: r[16*k +: 16] = 16'(run_len(v, 14, v[15]));
        2: r[16*k +: 16] = (sv < 0) ? 16'd0 : 16'(run_len(v, 15, 1'b0));
        3: r[16*k +: 16] = (sv >= 0) ? 16'd0 : 16'(run_len(v, 15, 1'b1));
        default: r[16*k +: 16] = s[16*(k ^ 1) +: 16];
      endcase
    end
    return r;
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [XLEN-1:0] s);
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; src_i = s;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic legal(input int op, input logic [XLEN-1:0] s, input string req,
                       input logic [4:0] rd = 5'd3, input logic [4:0] rs1 = 5'd7);
    logic clamp;
    logic [XLEN-1:0] e;
    e = model(op, s, clamp);
    issue(mk(op, rd, rs1), s);
    exp_sat = exp_sat | clamp;
    chk({req, " result"}, result_o, e);
    chk("R1 strobe", {63'd0, out_valid_o}, 1);
    chk("R1 legal", {63'd0, illegal_o}, 0);
    chk("R3 sat", {63'd0, sat_o}, {63'd0, exp_sat});
  endtask

  task automatic bad(input logic [31:0] ins, input logic [XLEN-1:0] s);
    issue(ins, s);
    chk("R8 illegal", {63'd0, illegal_o}, 1);
    chk("R8 zero", result_o, 0);
    chk("R8 sat held", {63'd0, sat_o}, {63'd0, exp_sat});
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    chk("R9 result", result_o, 0);
    chk("R9 strobe", {63'd0, out_valid_o}, 0);
    chk("R9 illegal", {63'd0, illegal_o}, 0);
    chk("R9 sat", {63'd0, sat_o}, 0);
    rst_n = 1'b1;

    // R8: near-miss encodings, including one that holds 0x8000
    bad({12'b1010110_10000, 5'd1, 3'b000, 5'd2, 7'b1111111}, 64'h8000_8000_8000_8000);
    bad({12'b1010110_10001, 5'd1, 3'b001, 5'd2, 7'b1111111}, 64'h8000_8000_8000_8000);
    bad({12'b1010110_10001, 5'd1, 3'b000, 5'd2, 7'b1110111}, 64'h8000_0000_0000_0000);
    bad({12'b1010111_01010, 5'd1, 3'b000, 5'd2, 7'b1111111}, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    chk("R1 idle strobe", {63'd0, out_valid_o}, 0);

    // R2
    legal(0, 64'h0001_FFFF_7FFF_8001, "R2 abs");
    // R4
    legal(1, 64'h0000_FFFF_0001_C000, "R4 sign repeats");
    // R5
    legal(2, 64'h0000_8000_0001_00FF, "R5 zeros");
    // R6
    legal(3, 64'hFFFF_7FFF_8000_FF00, "R6 ones");
    // R7
    legal(4, 64'h1111_2222_3333_4444, "R7 swap");
    // R10
    legal(2, 64'h0040_0400_4000_0004, "R10 fields", 5'd31, 5'd0);
    // R3: clamp then stickiness across other ops
    legal(0, 64'h8000_0005_FFFB_0000, "R3 abs clamp");
    legal(1, 64'h0F00_00F0_000F_F000, "R3 sticky");
    bad(32'h0, 64'h8000_8000_8000_8000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [XLEN-1:0] s;
      int op;
      for (int k = 0; k < LN; k++) begin
        case ($urandom % 6)
          0: s[16*k +: 16] = 16'h0000;
          1: s[16*k +: 16] = 16'hFFFF;
          2: s[16*k +: 16] = 16'h8000;
          3: s[16*k +: 16] = 16'h7FFF;
          default: s[16*k +: 16] = 16'($urandom);
        endcase
      end
      op = $urandom % 6;
      if (op == 5)
        bad({7'b1010111, 5'b11111, 5'($urandom), 3'b000, 5'($urandom), 7'b1111111}, s);
      else
        legal(op, s, "R1 random", 5'($urandom), 5'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule